// File: doc/BRIEF.md
# ADC Conversion Autosequencer

This block sequences a shared 10-bit analog-to-digital converter through a programmed list of up to sixteen conversions. Every entry in the list, called a slot, holds a 4-bit channel number that selects one of sixteen multiplexed inputs. For each granted slot the block puts the channel select on the converter port. It then raises a sample/hold strobe for a programmable acquisition window and pulses a convert start. It waits for the converter's done strobe and stores the returned 10-bit value in the result register that has the same index as the slot.

The list can be split into two independent halves, each with its own pointer, count and trigger sources. It can also be joined into a single sixteen-slot sequence. A trigger runs a programmed number of slots and then posts an end-of-sequence flag and an interrupt pulse. The interrupt can be set to fire on every completion or on every second one. In step mode a sequencer stops after its count and resumes from the following slot on the next trigger, so a series of triggers spaced in time covers successive groups of the list.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, busy, eos_flag, eos_irq, ovf_flag, adc_sample and adc_start are all 0, and every result register reads 0.
- R2: In dual mode (cascade=0), a trigger on trig_sw[0], trig_eva or trig_ext starts sequencer A. It converts slots 0 to max_conv_a[2:0]. Slot n uses the channel in chan_list[4n+3:4n], and its result is read back at rd_addr=n. The result is the adc_data value returned for that conversion.
- R3: In dual mode, a trigger on trig_sw[1] or trig_evb starts sequencer B. It converts slots 8 to 8+max_conv_b[2:0] and stores the results at those same indices.
- R4: With cascade=1, trig_sw[0], trig_eva, trig_evb and trig_ext all start sequencer A, which converts slots 0 to max_conv_a (0 to 15). Sequencer B ignores trig_sw[1] and its busy output stays 0.
- R5: For each conversion, adc_sample is high for exactly acq_len+1 consecutive cycles. It is followed at once by a one-cycle adc_start pulse during which adc_sample is low.
- R6: When both sequencers are waiting while the converter is idle, sequencer A is served first. Sequencer B starts no conversion until A has completed its run.
- R7: With step_mode=1, a sequencer resumes on each new trigger at the slot after the last one it converted. It wraps from its last slot (7 or 15 for A, 15 for B) to its first slot.
- R8: With step_mode=0, every trigger restarts the sequencer at its first slot.
- R9: A pulse on seq_rst[i] returns sequencer i's pointer to its first slot and clears ovf_flag[i].
- R10: A trigger that arrives while its sequencer is busy sets ovf_flag and has no other effect: the run still performs exactly its programmed number of conversions.
- R11: eos_flag[i] is set when sequencer i completes a run. It stays set until a cycle with eos_clr[i]=1. A completion in the same cycle as a clear leaves the flag set.
- R12: eos_irq[i] is a one-cycle pulse. With irq_alt[i]=0 it fires on every completion; with irq_alt[i]=1 it fires on the second, fourth and later even-numbered completions.
- R13: busy[i] is 1 from the cycle after an accepted trigger until the clock edge at which the run's last result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cascade | input | 1 | 1 joins both halves into one sixteen-slot sequence |
| step_mode | input | 1 | 1 makes each trigger resume from the next slot |
| irq_alt | input | 2 | Per sequencer: interrupt on every second completion |
| chan_list | input | 64 | Channel number per slot, slot n in bits 4n+3:4n |
| max_conv_a | input | 4 | Conversions per trigger minus one, sequencer A |
| max_conv_b | input | 4 | Conversions per trigger minus one, sequencer B (low 3 bits used) |
| acq_len | input | 4 | Acquisition window length minus one, in clocks |
| trig_sw | input | 2 | Software start pulse per sequencer |
| trig_eva | input | 1 | Event source A trigger |
| trig_evb | input | 1 | Event source B trigger |
| trig_ext | input | 1 | External start pin |
| seq_rst | input | 2 | Per sequencer: return pointer to first slot, clear overflow |
| eos_clr | input | 2 | Per sequencer: clear end-of-sequence flag |
| adc_chan | output | 4 | Channel select to the converter |
| adc_sample | output | 1 | Sample/hold acquisition strobe |
| adc_start | output | 1 | Convert start pulse |
| adc_done | input | 1 | Conversion finished, adc_data valid |
| adc_data | input | 10 | Conversion result |
| rd_addr | input | 4 | Result register index |
| rd_data | output | 10 | Addressed result register |
| busy | output | 2 | Sequencer running |
| eos_flag | output | 2 | Sticky end-of-sequence flag |
| eos_irq | output | 2 | End-of-sequence interrupt pulse |
| ovf_flag | output | 2 | Trigger arrived while busy |

## Verification
Two requests can collide in one cycle. When both sequencers are triggered on the same clock edge, both ask for the converter at once and the arbiter must choose. The bench fires trig_eva and trig_evb in the same cycle. It checks that at the moment sequencer A's end-of-sequence flag appears, sequencer B is still busy and has no flag of its own. It then checks that both sets of results are correct. A trigger that lands while its own run is in progress is also provoked. The bench counts adc_start pulses to show that the overflow changed nothing but the flag.

// File: rtl/adc_seq_pkg.sv
// Shared sizes and types for the conversion autosequencer.
// Assumes exactly two sequencers that share one converter.
package adc_seq_pkg;
    localparam int NUM_SLOTS = 16;
    localparam int CH_W      = 4;
    localparam int DATA_W    = 10;
    localparam int PS_W      = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int HALF      = NUM_SLOTS / 2;
    localparam int NUM_SEQ   = 2;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_ACQ,
        CV_START,
        CV_WAIT
    } conv_state_t;
endpackage

// File: rtl/adc_seq_ctl.sv
// One sequencer: holds the slot pointer, run count, busy, overflow,
// end-of-sequence flag and interrupt divider.
// Assumes conv_done is a one-cycle pulse that arrives only for a
// conversion this sequencer was granted.
module adc_seq_ctl #(
    parameter int IDX    = 0,
    parameter int SLOT_W = adc_seq_pkg::SLOT_W,
    parameter int HALF   = adc_seq_pkg::HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cascade,
    input  logic              step_mode,
    input  logic              alt_irq,
    input  logic              trig,
    input  logic              seq_rst,
    input  logic              eos_clr,
    input  logic              conv_done,
    input  logic [SLOT_W-1:0] max_conv,
    output logic              busy,
    output logic              eos_flag,
    output logic              eos_irq,
    output logic              ovf_flag,
    output logic [SLOT_W-1:0] slot
);
    localparam int LOW_W = SLOT_W - 1;
    localparam logic [SLOT_W-1:0] BASE = SLOT_W'(IDX * HALF);

    logic              long_mode;
    logic [SLOT_W-1:0] eff_max;
    logic [SLOT_W-1:0] last_ptr;
    logic [SLOT_W-1:0] ptr;
    logic [SLOT_W-1:0] ptr_next;
    logic [SLOT_W-1:0] cnt;
    logic              finish;
    logic              half_q;

    // Range and count limits for the current mode.
    always_comb begin
        long_mode = cascade && (IDX == 0);
        eff_max   = long_mode ? max_conv : {1'b0, max_conv[LOW_W-1:0]};
        last_ptr  = long_mode ? SLOT_W'(2 * HALF - 1) : SLOT_W'(HALF - 1);
        ptr_next  = (ptr == last_ptr) ? '0 : ptr + 1'b1;
        finish    = busy && conv_done && (cnt == eff_max);
    end

    assign slot = BASE + ptr;

    // Pointer, count, flags and interrupt update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            eos_flag <= 1'b0;
            eos_irq  <= 1'b0;
            ovf_flag <= 1'b0;
            half_q   <= 1'b0;
        end else begin
            eos_irq <= 1'b0;
            if (busy && conv_done) begin
                if (cnt == eff_max) begin
                    busy <= 1'b0;
                    ptr  <= step_mode ? ptr_next : '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    ptr <= ptr_next;
                end
            end
            if (trig) begin
                if (busy) begin
                    ovf_flag <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    cnt  <= '0;
                    if (!step_mode) ptr <= '0;
                end
            end
            if (seq_rst) begin
                ptr      <= '0;
                ovf_flag <= 1'b0;
            end
            if (!alt_irq) half_q <= 1'b0;
            if (finish) begin
                eos_flag <= 1'b1;
                if (!alt_irq) begin
                    eos_irq <= 1'b1;
                end else if (half_q) begin
                    eos_irq <= 1'b1;
                    half_q  <= 1'b0;
                end else begin
                    half_q <= 1'b1;
                end
            end else if (eos_clr) begin
                eos_flag <= 1'b0;
            end
        end
    end

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy && !seq_rst) |=> ovf_flag);
    // R11
    eos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_flag && !eos_clr) |=> eos_flag);
    // R12
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_irq |-> eos_flag);
    // R13
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eos_flag);
endmodule

// File: rtl/adc_conv_ctl.sv
// Converter front end: picks the next sequencer (A before B), drives
// channel, acquisition strobe and convert start, and returns the result.
// Assumes adc_done is a one-cycle pulse some cycles after adc_start.
module adc_conv_ctl
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int SW      = SLOT_W,
    parameter int CW      = CH_W,
    parameter int DW      = DATA_W,
    parameter int PW      = PS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         req,
    input  logic [SW-1:0]      slot_a,
    input  logic [SW-1:0]      slot_b,
    input  logic [N_SLOTS*CW-1:0] chan_list,
    input  logic [PW-1:0]      acq_len,
    input  logic               adc_done,
    input  logic [DW-1:0]      adc_data,
    output logic [CW-1:0]      adc_chan,
    output logic               adc_sample,
    output logic               adc_start,
    output logic [1:0]         done,
    output logic               wr_en,
    output logic [SW-1:0]      wr_addr,
    output logic [DW-1:0]      wr_data
);
    conv_state_t   state;
    logic          owner;
    logic [SW-1:0] slot_q;
    logic [PW-1:0] acq_cnt;
    logic [SW-1:0] pick_slot;
    logic          finished;

    // Fixed priority: sequencer A wins when both ask.
    assign pick_slot = req[0] ? slot_a : slot_b;

    // Converter handshake decode.
    always_comb begin
        adc_sample = (state == CV_ACQ);
        adc_start  = (state == CV_START);
        finished   = (state == CV_WAIT) && adc_done;
        done[0]    = finished && !owner;
        done[1]    = finished && owner;
        wr_en      = finished;
        wr_addr    = slot_q;
        wr_data    = adc_data;
    end

    // Grant, acquisition countdown and wait for the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CV_IDLE;
            owner    <= 1'b0;
            slot_q   <= '0;
            acq_cnt  <= '0;
            adc_chan <= '0;
        end else begin
            unique case (state)
                CV_IDLE: if (|req) begin
                    owner    <= !req[0];
                    slot_q   <= pick_slot;
                    adc_chan <= chan_list[int'(pick_slot) * CW +: CW];
                    acq_cnt  <= acq_len;
                    state    <= CV_ACQ;
                end
                CV_ACQ: begin
                    if (acq_cnt == '0) state <= CV_START;
                    else acq_cnt <= acq_cnt - 1'b1;
                end
                CV_START: state <= CV_WAIT;
                CV_WAIT:  if (adc_done) state <= CV_IDLE;
                default:  state <= CV_IDLE;
            endcase
        end
    end

    // R5
    start_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !adc_sample);
    // R5
    sample_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sample) |-> adc_start);
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> (!adc_start && !adc_sample));
    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));
endmodule

// File: rtl/adc_result_bank.sv
// Sixteen individually addressable result registers; one write port from
// the converter front end, one combinational read port.
module adc_result_bank #(
    parameter int N_SLOTS = adc_seq_pkg::NUM_SLOTS,
    parameter int SW      = adc_seq_pkg::SLOT_W,
    parameter int DW      = adc_seq_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [N_SLOTS];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_reg
        // Capture a result addressed to this register.
        always_ff @(posedge clk) begin
            if (!rst_n) mem[g] <= '0;
            else if (wr_en && (wr_addr == SW'(g))) mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/adc_autoseq.sv
// Top of the autosequencer: routes triggers by mode to two sequencers,
// shares one converter front end, and stores results.
// Assumes trigger inputs are single-cycle synchronous pulses.
module adc_autoseq
    import adc_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cascade,
    input  logic                      step_mode,
    input  logic [NUM_SEQ-1:0]        irq_alt,
    input  logic [NUM_SLOTS*CH_W-1:0] chan_list,
    input  logic [SLOT_W-1:0]         max_conv_a,
    input  logic [SLOT_W-1:0]         max_conv_b,
    input  logic [PS_W-1:0]           acq_len,
    input  logic [NUM_SEQ-1:0]        trig_sw,
    input  logic                      trig_eva,
    input  logic                      trig_evb,
    input  logic                      trig_ext,
    input  logic [NUM_SEQ-1:0]        seq_rst,
    input  logic [NUM_SEQ-1:0]        eos_clr,
    output logic [CH_W-1:0]           adc_chan,
    output logic                      adc_sample,
    output logic                      adc_start,
    input  logic                      adc_done,
    input  logic [DATA_W-1:0]         adc_data,
    input  logic [SLOT_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_SEQ-1:0]        busy,
    output logic [NUM_SEQ-1:0]        eos_flag,
    output logic [NUM_SEQ-1:0]        eos_irq,
    output logic [NUM_SEQ-1:0]        ovf_flag
);
    logic [NUM_SEQ-1:0] trig_v;
    logic [NUM_SEQ-1:0] done_v;
    logic [SLOT_W-1:0]  slot_v [NUM_SEQ];
    logic [SLOT_W-1:0]  max_v  [NUM_SEQ];
    logic               wr_en;
    logic [SLOT_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;

    // Trigger routing: cascade sends every source to sequencer A.
    always_comb begin
        trig_v[0] = trig_sw[0] | trig_eva | trig_ext | (cascade & trig_evb);
        trig_v[1] = !cascade & (trig_sw[1] | trig_evb);
        max_v[0]  = max_conv_a;
        max_v[1]  = max_conv_b;
    end

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        adc_seq_ctl #(.IDX(g), .SLOT_W(SLOT_W), .HALF(HALF)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .cascade   (cascade),
            .step_mode (step_mode),
            .alt_irq   (irq_alt[g]),
            .trig      (trig_v[g]),
            .seq_rst   (seq_rst[g]),
            .eos_clr   (eos_clr[g]),
            .conv_done (done_v[g]),
            .max_conv  (max_v[g]),
            .busy      (busy[g]),
            .eos_flag  (eos_flag[g]),
            .eos_irq   (eos_irq[g]),
            .ovf_flag  (ovf_flag[g]),
            .slot      (slot_v[g])
        );
    end

    adc_conv_ctl u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (busy),
        .slot_a     (slot_v[0]),
        .slot_b     (slot_v[1]),
        .chan_list  (chan_list),
        .acq_len    (acq_len),
        .adc_done   (adc_done),
        .adc_data   (adc_data),
        .adc_chan   (adc_chan),
        .adc_sample (adc_sample),
        .adc_start  (adc_start),
        .done       (done_v),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    adc_result_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R4
    casc_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !busy[1]) |=> !busy[1]);
endmodule

// File: tb/sim_adc_autoseq.sv
// Bench for adc_autoseq: a converter model, a vector table walked by one
// loop, then directed tests for reset, ordering and corner cases.
module sim_adc_autoseq;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cascade, step_mode;
    logic [1:0]  irq_alt, trig_sw, seq_rst, eos_clr;
    logic [63:0] chan_list;
    logic [3:0]  max_conv_a, max_conv_b, acq_len, rd_addr;
    logic        trig_eva, trig_evb, trig_ext;
    logic [3:0]  adc_chan;
    logic        adc_sample, adc_start;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_data = '0;
    logic [9:0]  rd_data;
    logic [1:0]  busy, eos_flag, eos_irq, ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_autoseq u0 (
        .clk(clk), .rst_n(rst_n), .cascade(cascade), .step_mode(step_mode),
        .irq_alt(irq_alt), .chan_list(chan_list), .max_conv_a(max_conv_a),
        .max_conv_b(max_conv_b), .acq_len(acq_len), .trig_sw(trig_sw),
        .trig_eva(trig_eva), .trig_evb(trig_evb), .trig_ext(trig_ext),
        .seq_rst(seq_rst), .eos_clr(eos_clr), .adc_chan(adc_chan),
        .adc_sample(adc_sample), .adc_start(adc_start), .adc_done(adc_done),
        .adc_data(adc_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .eos_flag(eos_flag), .eos_irq(eos_irq), .ovf_flag(ovf_flag)
    );

    function automatic logic [9:0] conv_val(input logic [3:0] ch);
        return {2'b10, ch, ~ch};
    endfunction

    function automatic logic [3:0] chan_of(input int s, input int k);
        return 4'((s * 5 + k * 3 + 1) % 16);
    endfunction

    // Converter model: result three cycles after a start pulse.
    int lat = 0;
    always @(posedge clk) begin
        adc_done <= 1'b0;
        if (adc_start) lat <= 3;
        else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                adc_done <= 1'b1;
                adc_data <= conv_val(adc_chan);
            end
        end
    end

    // Monitors: sample window length, start pulses, interrupt pulses.
    int run_w = 0, last_w = 0, n_starts = 0, irq_a = 0;
    always @(posedge clk) begin
        if (adc_sample) run_w <= run_w + 1;
        else if (run_w != 0) begin
            last_w <= run_w;
            run_w  <= 0;
        end
        if (adc_start) n_starts <= n_starts + 1;
        if (eos_irq[0]) irq_a <= irq_a + 1;
    end

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic load_list(input int k);
        for (int s = 0; s < 16; s++) chan_list[s*4 +: 4] = chan_of(s, k);
    endtask

    task automatic read_res(input int s, output int v);
        rd_addr = 4'(s);
        #1;
        v = int'(rd_data);
    endtask

    task automatic fire(input logic [1:0] sw, input logic a, input logic b,
                        input logic x);
        @(negedge clk);
        trig_sw = sw; trig_eva = a; trig_evb = b; trig_ext = x;
        @(negedge clk);
        trig_sw = '0; trig_eva = 0; trig_evb = 0; trig_ext = 0;
    endtask

    task automatic pulse_rst(input logic [1:0] m);
        @(negedge clk); seq_rst = m;
        @(negedge clk); seq_rst = '0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); eos_clr = m;
        @(negedge clk); eos_clr = '0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy != 2'b00 && t < WAIT_MAX) begin
            @(negedge clk);
            t++;
        end
        if (t >= WAIT_MAX) check("R13 busy timeout", t, 0);
    endtask

    task automatic check_range(input string rq, input int lo, input int hi,
                               input int k);
        int v;
        for (int s = lo; s <= hi; s++) begin
            read_res(s, v);
            check(rq, v, int'(conv_val(chan_of(s, k))));
        end
    endtask

    // Vector fields: cascade, which(1=A 2=B 3=both), max_a, max_b, acq, src.
    // src: 0 software, 1 event source, 2 external pin.
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 2'd1, 4'd7,  4'd0, 4'd0, 2'd0},
        {1'b0, 2'd2, 4'd0,  4'd7, 4'd2, 2'd1},
        {1'b0, 2'd3, 4'd3,  4'd5, 4'd1, 2'd1},
        {1'b1, 2'd1, 4'd15, 4'd0, 4'd3, 2'd1},
        {1'b1, 2'd1, 4'd4,  4'd0, 4'd0, 2'd2},
        {1'b0, 2'd3, 4'd0,  4'd0, 4'd5, 2'd0}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, base, k;
        rst_n = 0; cascade = 0; step_mode = 0; irq_alt = '0;
        trig_sw = '0; trig_eva = 0; trig_evb = 0; trig_ext = 0;
        seq_rst = '0; eos_clr = '0; max_conv_a = '0; max_conv_b = '0;
        acq_len = '0; rd_addr = '0; chan_list = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 eos_flag", int'(eos_flag), 0);
        check("R1 ovf_flag", int'(ovf_flag), 0);
        check("R1 irq/sample/start", int'({eos_irq, adc_sample, adc_start}), 0);
        read_res(5, v);  check("R1 result", v, 0);
        read_res(12, v); check("R1 result", v, 0);

        // Table walk: R2, R3, R4, R5, R11
        for (int e = 0; e < 6; e++) begin
            logic [16:0] f;
            int ma, mb;
            f = VEC[e];
            cascade = f[16]; max_conv_a = f[13:10]; max_conv_b = f[9:6];
            acq_len = f[5:2];
            ma = cascade ? int'(f[13:10]) : int'(f[12:10]);
            mb = int'(f[8:6]);
            load_list(e);
            pulse_rst(2'b11);
            fire({f[15] & (f[1:0] == 2'd0), f[14] & (f[1:0] == 2'd0)},
                 f[14] & !f[16] & (f[1:0] == 2'd1),
                 ((f[15] & !f[16]) | (f[16] & f[14])) & (f[1:0] == 2'd1),
                 f[14] & (f[1:0] == 2'd2));
            wait_idle();
            if (f[14]) check_range(cascade ? "R4 cascade result" : "R2 result A",
                                   0, ma, e);
            if (f[15]) check_range("R3 result B", 8, 8 + mb, e);
            check("R5 sample window", last_w, int'(f[5:2]) + 1);
            check("R11 flag set", int'(eos_flag), int'(f[15:14]));
            repeat (4) @(negedge clk);
            check("R11 flag held", int'(eos_flag), int'(f[15:14]));
            pulse_clr(2'b11);
            check("R11 flag cleared", int'(eos_flag), 0);
        end

        // R4: sequencer B trigger ignored in cascade mode
        cascade = 1;
        fire(2'b10, 0, 0, 0);
        check("R4 seq B stays idle", int'(busy), 0);
        cascade = 0;

        // R6: both triggered in one cycle, A served first
        max_conv_a = 4'd3; max_conv_b = 4'd3; acq_len = 4'd1;
        load_list(7);
        pulse_rst(2'b11);
        fire(2'b00, 1, 1, 0);
        begin
            int t = 0;
            while (!eos_flag[0] && t < WAIT_MAX) begin @(negedge clk); t++; end
        end
        check("R6 B still busy when A ends", int'(busy[1]), 1);
        check("R6 B no flag when A ends", int'(eos_flag[1]), 0);
        wait_idle();
        check_range("R6 results A", 0, 3, 7);
        check_range("R6 results B", 8, 11, 7);
        pulse_clr(2'b11);

        // R13: busy the cycle after the trigger
        max_conv_a = 4'd0;
        check("R13 idle before", int'(busy[0]), 0);
        fire(2'b01, 0, 0, 0);
        check("R13 busy after trigger", int'(busy[0]), 1);
        wait_idle();
        check("R13 idle after run", int'(busy[0]), 0);

        // R7 step mode continue and wrap, R9 pointer reset, R8 restart
        step_mode = 1; max_conv_a = 4'd2;
        pulse_rst(2'b01);
        load_list(10);
        fire(2'b00, 1, 0, 0); wait_idle();
        load_list(11);
        fire(2'b00, 1, 0, 0); wait_idle();
        read_res(0, v); check("R7 slot0 untouched", v, int'(conv_val(chan_of(0, 10))));
        read_res(3, v); check("R7 resumed at slot3", v, int'(conv_val(chan_of(3, 11))));
        fire(2'b00, 1, 0, 0); wait_idle();
        read_res(7, v); check("R7 slot7", v, int'(conv_val(chan_of(7, 11))));
        read_res(0, v); check("R7 wrap to slot0", v, int'(conv_val(chan_of(0, 11))));
        pulse_rst(2'b01);
        load_list(12);
        fire(2'b00, 1, 0, 0); wait_idle();
        read_res(0, v); check("R9 restart slot0", v, int'(conv_val(chan_of(0, 12))));
        read_res(3, v); check("R9 slot3 untouched", v, int'(conv_val(chan_of(3, 11))));
        step_mode = 0; max_conv_a = 4'd1;
        load_list(13);
        fire(2'b00, 1, 0, 0); wait_idle();
        read_res(0, v); check("R8 restart slot0", v, int'(conv_val(chan_of(0, 13))));
        read_res(2, v); check("R8 slot2 untouched", v, int'(conv_val(chan_of(2, 12))));
        read_res(3, v); check("R8 slot3 untouched", v, int'(conv_val(chan_of(3, 11))));
        pulse_clr(2'b11);

        // R10 overflow, then R9 clears it
        max_conv_a = 4'd3;
        base = n_starts;
        fire(2'b00, 1, 0, 0);
        repeat (2) @(negedge clk);
        fire(2'b00, 1, 0, 0);
        check("R10 overflow set", int'(ovf_flag[0]), 1);
        wait_idle();
        @(negedge clk);
        check("R10 conversions unchanged", n_starts - base, 4);
        pulse_rst(2'b01);
        check("R9 overflow cleared", int'(ovf_flag[0]), 0);

        // R12 interrupt on every / every second completion
        max_conv_a = 4'd0; irq_alt = 2'b00;
        base = irq_a;
        for (int i = 0; i < 2; i++) begin fire(2'b01, 0, 0, 0); wait_idle(); end
        repeat (2) @(negedge clk);
        check("R12 every completion", irq_a - base, 2);
        irq_alt = 2'b01;
        base = irq_a;
        k = 0;
        for (int i = 0; i < 4; i++) begin
            fire(2'b01, 0, 0, 0); wait_idle();
            repeat (2) @(negedge clk);
            if (i == 0) k = irq_a - base;
        end
        check("R12 none on first", k, 0);
        check("R12 every second completion", irq_a - base, 2);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end
endmodule